// File: doc/BRIEF.md
# PLL Lock and Bandwidth Mode Detector

This block watches two divided clocks from a phase-locked loop, the divided reference and the divided feedback. It judges from their relative frequency whether the loop has settled. Over a window of a fixed number of reference periods it counts the feedback edges that arrive. The distance between that count and the window length is the frequency error for the window. The error drives two decisions. The first is whether the loop filter runs in a wide-bandwidth acquisition setting, which allows large corrections, or in a narrow-bandwidth tracking setting, which allows only small corrections and gives lower jitter. The second is whether a lock flag is raised.

Both divided clocks are asynchronous to the system clock. Each is brought in through a two-flop synchronizer before its rising edges are detected. The window length is tied to the reference clock, so detection runs faster when the reference runs faster. In automatic mode the bandwidth setting follows the error history. With automatic mode off, a software bit sets the mode directly. The status output reads 0 in acquisition and 1 in tracking.

Top module: `pll_lock_mode_det`

## Requirements
- R1: While reset is held and in the first cycle after it, acq_stat, filt_narrow and locked are all 0. This means automatic acquisition with no lock.
- R2: A window closes on every REF_WIN-th (16th) synchronized rising edge of ref_div. Its count is the number of synchronized rising edges of fb_div seen since the previous close, including an edge on the closing cycle. Its error is the absolute difference between that count and REF_WIN.
- R3: With auto_en=1 and in acquisition, the block moves to tracking (acq_stat=1) at the close of the second consecutive window whose error is at most 1, and at no other time.
- R4: With auto_en=1 and in tracking, a window with an error above 3 returns the block to acquisition (acq_stat=0) in the cycle after that window closes.
- R5: With auto_en=1, a window whose error is 2 or 3 leaves the mode unchanged.
- R6: locked rises only while tracking, at the close of the fourth or later consecutive window with an error of at most 1. When tracking was entered from a run of such windows, locked rises exactly two windows (2*REF_WIN reference periods) after acq_stat rises.
- R7: locked falls in the cycle after any window closes with an error above 1.
- R8: With auto_en=0, acq_stat equals the value acq_sw had in the previous cycle (0 = acquisition, 1 = tracking). locked is then 1 only while acq_sw=1 and the last four or more windows had an error of at most 1.
- R9: filt_narrow is 1 exactly when the block is in tracking and 0 in acquisition.
- R10: ref_div and fb_div may change at any time relative to clk. Each passes through two synchronizing flops before edge detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_div | input | 1 | Divided reference clock, asynchronous |
| fb_div | input | 1 | Divided feedback clock, asynchronous |
| auto_en | input | 1 | 1 = mode chosen from frequency error, 0 = mode set by acq_sw |
| acq_sw | input | 1 | Software mode bit used when auto_en=0: 0 acquisition, 1 tracking |
| acq_stat | output | 1 | Mode status: 0 acquisition, 1 tracking |
| filt_narrow | output | 1 | Loop filter bandwidth select: 1 narrow (tracking), 0 wide |
| locked | output | 1 | Lock flag |

## Verification
The bench measures the gap between the rise of acq_stat and the rise of locked after a clean frequency match. A design that counted its window runs wrongly, or cleared the run on entering tracking, would show a gap other than two windows. A feedback clock whose error sits at 2 or 3 must drop the lock without leaving tracking, and must not pull the block out of acquisition. A design that merged the two thresholds would change mode there. Manual override is checked one cycle after each write, with the lock flag gated by the forced mode. Randomized sequences of good, marginal and far-off frequencies, mixed with automatic and manual control, are checked against a bench model of the mode and lock state.

// File: rtl/pll_lock_mode_det.sv
module pll_lock_mode_det #(
  parameter int REF_WIN   = 16,
  parameter int CNT_W     = 8,
  parameter int ENTER_TOL = 1,
  parameter int EXIT_TOL  = 3,
  parameter int ENTER_RUN = 2,
  parameter int LOCK_RUN  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_div,
  input  logic fb_div,
  input  logic auto_en,
  input  logic acq_sw,
  output logic acq_stat,
  output logic filt_narrow,
  output logic locked
);
  localparam int RW    = $clog2(REF_WIN);
  localparam int RUN_W = $clog2(LOCK_RUN + 1);
  localparam logic [CNT_W:0] WIN_C  = (CNT_W+1)'(REF_WIN);
  localparam logic [CNT_W:0] ENT_C  = (CNT_W+1)'(ENTER_TOL);
  localparam logic [CNT_W:0] EXIT_C = (CNT_W+1)'(EXIT_TOL);

  // two sync stages plus one history stage per input (R10)
  logic [2:0] ref_s, fb_s;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_s <= '0;
      fb_s  <= '0;
    end else begin
      ref_s <= {ref_s[1:0], ref_div};
      fb_s  <= {fb_s[1:0], fb_div};
    end
  end

  logic ref_rise, fb_rise;
  assign ref_rise = ref_s[1] & ~ref_s[2];
  assign fb_rise  = fb_s[1] & ~fb_s[2];

  logic [RW-1:0] ref_cnt;
  logic          win_end;
  assign win_end = ref_rise && (ref_cnt == RW'(REF_WIN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)        ref_cnt <= '0;
    else if (win_end)  ref_cnt <= '0;
    else if (ref_rise) ref_cnt <= ref_cnt + 1'b1;
  end

  logic [CNT_W-1:0] fb_cnt;
  logic [CNT_W:0]   fb_tot, err;
  assign fb_tot = {1'b0, fb_cnt} + (CNT_W+1)'(fb_rise);
  assign err    = (fb_tot >= WIN_C) ? fb_tot - WIN_C : WIN_C - fb_tot;

  always_ff @(posedge clk) begin
    if (!rst_n)                     fb_cnt <= '0;
    else if (win_end)               fb_cnt <= '0;
    else if (fb_rise && !(&fb_cnt)) fb_cnt <= fb_cnt + 1'b1;
  end

  logic good, bad;
  assign good = err <= ENT_C;
  assign bad  = err > EXIT_C;

  logic [RUN_W-1:0] run_q, run_n;
  assign run_n = !good ? '0 :
                 (run_q == RUN_W'(LOCK_RUN)) ? run_q : run_q + 1'b1;

  logic track_q, track_n, lock_ok;
  always_comb begin
    track_n = track_q;
    if (!auto_en)
      track_n = acq_sw;
    else if (win_end) begin
      if (track_q && bad)
        track_n = 1'b0;
      else if (!track_q && good && run_n >= RUN_W'(ENTER_RUN))
        track_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= '0;
      lock_ok <= 1'b0;
      track_q <= 1'b0;
    end else begin
      track_q <= track_n;
      if (win_end) begin
        run_q   <= run_n;
        lock_ok <= good && (run_n >= RUN_W'(LOCK_RUN));
      end
    end
  end

  assign acq_stat    = track_q;
  assign filt_narrow = track_q;
  assign locked      = lock_ok & track_q;

  p_lock_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    win_end && !good |=> !locked);

  p_exit_acq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    auto_en && win_end && bad |=> !acq_stat);

  p_manual_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |=> acq_stat == $past(acq_sw));

  p_enter_at_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    auto_en && !acq_stat && !win_end |=> !acq_stat);

  p_lock_at_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    auto_en && !locked && !win_end |=> !locked);
endmodule

// File: tb/tb_pll_lock_mode_det.sv
`timescale 1ns/1ps
module tb_pll_lock_mode_det;
  localparam int WIN_CYC = 640;   // 16 ref periods of 40 sys cycles
  localparam int GOOD = 0, MID = 1, BAD = 2, SLOW = 3;

  logic clk = 0, rst_n = 0, ref_div = 0, fb_div = 0, auto_en = 1, acq_sw = 0;
  logic acq_stat, filt_narrow, locked;
  int   fb_half = 20;
  int   checks = 0, errors = 0;

  pll_lock_mode_det dut (.clk(clk), .rst_n(rst_n), .ref_div(ref_div), .fb_div(fb_div),
    .auto_en(auto_en), .acq_sw(acq_sw), .acq_stat(acq_stat),
    .filt_narrow(filt_narrow), .locked(locked));

  always #2.5 clk = ~clk;
  initial forever #100 ref_div = ~ref_div;
  initial begin
    #37;
    forever #(fb_half * 5.0) fb_div = ~fb_div;
  end

  function automatic int half_of(int cls);
    case (cls)
      GOOD:    return 20;  // 16 edges, error 0..1
      MID:     return 17;  // about 18.8 edges, error 2..3
      BAD:     return 14;  // about 22.9 edges, error 6..7
      default: return 30;  // about 10.7 edges, error 5..6
    endcase
  endfunction

  function automatic bit exp_track(bit prev, int cls, bit au, bit sw);
    if (!au) return sw;
    if (cls == GOOD) return 1'b1;
    if (cls == MID) return prev;
    return 1'b0;
  endfunction

  function automatic bit exp_lock(int cls, bit au, bit sw);
    return (cls == GOOD) && (au || sw);
  endfunction

  task automatic chk(string req, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  int t_track, t_lock;
  bit prev_track;
  int prev_cls;

  initial begin
    int cyc;
    cyc = 0;
    while (cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    wait_cyc(5);
    chk("R1 acq_stat in reset", acq_stat, 0);
    chk("R1 locked in reset", locked, 0);
    rst_n = 1;
    wait_cyc(1);
    chk("R1 acq_stat after reset", acq_stat, 0);
    chk("R9 filt_narrow after reset", filt_narrow, 0);
    chk("R1 locked after reset", locked, 0);

    // matched frequencies: tracking then lock (R2, R3, R6, R9)
    wait_cyc(8 * WIN_CYC);
    chk("R3 tracking on match", acq_stat, 1);
    chk("R9 narrow in tracking", filt_narrow, 1);
    chk("R6 locked on match", locked, 1);

    // marginal error: lock drops, tracking holds (R7, R5)
    fb_half = half_of(MID);
    wait_cyc(2 * WIN_CYC + 50);
    chk("R7 lock drops on error 2..3", locked, 0);
    chk("R5 tracking held on error 2..3", acq_stat, 1);
    wait_cyc(5 * WIN_CYC);
    chk("R5 tracking still held", acq_stat, 1);

    // far off: back to acquisition (R4)
    fb_half = half_of(BAD);
    wait_cyc(2 * WIN_CYC + 50);
    chk("R4 acquisition on large error", acq_stat, 0);
    chk("R9 wide in acquisition", filt_narrow, 0);

    // marginal while acquiring: stays acquiring (R5)
    fb_half = half_of(MID);
    wait_cyc(6 * WIN_CYC);
    chk("R5 acquisition held on error 2..3", acq_stat, 0);

    // clean match again: lock rises exactly two windows after tracking (R3, R6)
    fb_half = half_of(GOOD);
    t_track = -1; t_lock = -1;
    for (int i = 0; i < 8 * WIN_CYC; i++) begin
      @(negedge clk);
      if (t_track < 0 && acq_stat) t_track = i;
      if (t_lock < 0 && locked) t_lock = i;
      if (locked && !acq_stat) chk("R6 lock only in tracking", 1'b1, 1'b0);
    end
    chk("R3 tracking reached", t_track >= 0, 1);
    checks++;
    if (t_lock - t_track != 2 * WIN_CYC) begin
      errors++;
      $display("FAIL R6 lock-to-track gap actual=%0d expected=%0d", t_lock - t_track, 2 * WIN_CYC);
    end

    // manual override (R8)
    auto_en = 0; acq_sw = 0;
    wait_cyc(1);
    chk("R8 manual acquisition next cycle", acq_stat, 0);
    chk("R8 lock gated by manual acquisition", locked, 0);
    acq_sw = 1;
    wait_cyc(1);
    chk("R8 manual tracking next cycle", acq_stat, 1);
    chk("R8 lock kept on good windows", locked, 1);
    fb_half = half_of(BAD);
    wait_cyc(3 * WIN_CYC);
    chk("R8 manual tracking despite large error", acq_stat, 1);
    chk("R7 lock cleared on large error", locked, 0);
    auto_en = 1;
    wait_cyc(2 * WIN_CYC + 50);
    chk("R4 auto resumes and leaves tracking", acq_stat, 0);

    // randomized segments against the bench model
    prev_track = 0; prev_cls = BAD;
    for (int s = 0; s < 14; s++) begin
      int cls;
      bit au, sw, et, el;
      cls = int'($urandom_range(0, 3));
      au = $urandom_range(0, 3) != 0;
      sw = 1'($urandom_range(0, 1));
      if (cls == MID && prev_cls != GOOD && prev_cls != MID) cls = GOOD;
      fb_half = half_of(cls);
      auto_en = au; acq_sw = sw;
      wait_cyc(8 * WIN_CYC);
      et = exp_track(prev_track, cls, au, sw);
      el = exp_lock(cls, au, sw);
      chk($sformatf("R3/R4/R5/R8 random mode seg %0d", s), acq_stat, et);
      chk($sformatf("R9 random filter seg %0d", s), filt_narrow, et);
      chk($sformatf("R6/R7 random lock seg %0d", s), locked, el);
      prev_track = et; prev_cls = cls;
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule